// File: doc/BRIEF.md
# BCH Sector Bit Corrector

This block repairs one 512-byte sector held in a local byte-wide buffer, using the result of a hardware BCH decoder. The decoder reports how many errors it found and up to eight packed 13-bit error locations. The locations are spread over three 32-bit result words and one status word. On a start pulse the block latches these words and the stored ECC bytes of the sector. It then takes the reported locations one after another. Each location becomes a bit address, and the block flips the addressed data bit with a single-cycle read-invert-write.

A reported count above the correctable limit does not fail at once. The block first runs an erased-sector test. It counts the zero bits in the stored ECC bytes and then in the data bytes, and stops as soon as the running total goes past the limit. A sector with only a few zero bits is taken to be a freshly erased page with a few stuck bits: the data is overwritten with all-ones, and the number of zero bits that were in the data is reported as the corrected count. Otherwise the sector is flagged uncorrectable and left untouched. A host byte port loads and reads the buffer while the engine is idle.

Top module: `sector_bitfix`

## Requirements
- R1: After reset, `done`, `fix_count` and `uncorrectable` are all 0.
- R2: A start with an error count of 0 (status bits 13:10) leaves the buffer unchanged. `done` rises on the clock edge that follows the start edge, with `fix_count` = 0 and `uncorrectable` = 0.
- R3: Form a 104-bit vector by placing status bits 23:16 above result word 3, word 3 above word 2, and word 2 above word 1. Location k is bits 13k+12 down to 13k of that vector, for k from 0 to 7. All other status bits are ignored.
- R4: The bit address of a location is the location with its two least significant bits inverted. Address n names byte n/8, bit n%8 of the buffer, and a correction inverts exactly that bit.
- R5: A bit address of 4096 or above is skipped without changing the buffer and is not counted. `fix_count` is the number of corrections applied, and a location that repeats is applied, and counted, each time it appears.
- R6: For an error count N from 1 to 8, only locations 0 to N-1 are used. Later locations have no effect even if they hold valid addresses.
- R7: For an error count above 8, the zero bits in the 13 stored ECC bytes and the 512 data bytes are totalled (ECC byte j is `ecc_stored` bits 8j+7:8j). If the total is 8 or less, every data byte becomes 0xFF, `fix_count` equals the number of zero bits that were in the data, and `uncorrectable` is 0.
- R8: If that total is above 8, `uncorrectable` is 1, `fix_count` is 0, and the buffer is unchanged.
- R9: `done` is high for exactly one cycle per operation. `fix_count` and `uncorrectable` change only in the cycle in which `done` is high, and they hold their values until the next operation completes.
- R10: While idle, a host write stores `host_wdata` at byte `host_addr`. A host read returns the byte at `host_addr` on `host_rdata` one clock after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle pulse that latches the decoder words and begins an operation |
| res_w1 | input | 32 | Decoder result word 1 |
| res_w2 | input | 32 | Decoder result word 2 |
| res_w3 | input | 32 | Decoder result word 3 |
| res_status | input | 32 | Decoder status word: error count and high bits of the last location |
| ecc_stored | input | 104 | The 13 ECC bytes read from the spare area, byte 0 lowest |
| host_we | input | 1 | Host byte write enable, honoured while idle |
| host_addr | input | 9 | Host byte address |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data, one cycle after the address |
| done | output | 1 | One-cycle completion pulse |
| fix_count | output | 4 | Corrected bit count |
| uncorrectable | output | 1 | Sector cannot be repaired |

## Verification
Several cases are hard to reach. One is a start whose error count is within the limit but whose first N locations mix in-range addresses, out-of-range addresses and a repeat, while the locations after N hold valid addresses that must stay unused. The bench builds that case by packing chosen locations into the four words, including locations that straddle word boundaries. The other hard cases are the two edges of the erased test: a zero-bit total of exactly 8 and one of exactly 9. The bench reaches them by loading an all-ones sector with a counted number of cleared data bits and choosing the ECC bytes to supply the rest. One ECC-only case crosses the limit before the data scan has begun.

// File: rtl/sbf_pkg.sv
package sbf_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_FIX,
      ST_ECC,
      ST_DATA,
      ST_ERASE,
      ST_DONE
   } sbf_state_e;

endpackage

// File: rtl/sbf_loc_unpack.sv
module sbf_loc_unpack #(
   parameter int LOC_W  = 13,
   parameter int N_LOC  = 8,
   parameter int WORD_W = 32,
   parameter int EXT_W  = N_LOC * LOC_W - 3 * WORD_W
) (
   input  logic [WORD_W-1:0]            word1,
   input  logic [WORD_W-1:0]            word2,
   input  logic [WORD_W-1:0]            word3,
   input  logic [EXT_W-1:0]             ext,
   output logic [N_LOC-1:0][LOC_W-1:0]  locs
);

   localparam int FLAT_W = 3 * WORD_W + EXT_W;

   initial begin
      if (FLAT_W != N_LOC * LOC_W)
         $fatal(1, "sbf_loc_unpack: packed width does not match location count");
      if (EXT_W < 1)
         $fatal(1, "sbf_loc_unpack: extension field must be at least one bit");
   end

   logic [FLAT_W-1:0] flat;
   assign flat = {ext, word3, word2, word1};

   for (genvar k = 0; k < N_LOC; k++) begin : g_loc
      assign locs[k] = flat[k*LOC_W +: LOC_W];
   end

endmodule

// File: rtl/sbf_zero_count.sv
module sbf_zero_count #(
   parameter int DATA_W = 8,
   parameter int CW     = $clog2(DATA_W + 1)
) (
   input  logic [DATA_W-1:0] din,
   output logic [CW-1:0]     zeros
);

   always_comb begin
      zeros = '0;
      for (int i = 0; i < DATA_W; i++) begin
         if (!din[i]) zeros = zeros + CW'(1);
      end
   end

endmodule

// File: rtl/sbf_byte_ram.sv
module sbf_byte_ram #(
   parameter int DEPTH      = 512,
   parameter int DATA_W     = 8,
   parameter bit HOST_RD_REG = 1'b1,
   parameter int ADDR_W     = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [ADDR_W-1:0] eng_addr,
   output logic [DATA_W-1:0] eng_rdata,
   input  logic [ADDR_W-1:0] host_addr,
   output logic [DATA_W-1:0] host_rdata
);

   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   assign eng_rdata = mem[eng_addr];

   if (HOST_RD_REG) begin : g_rd_reg
      always_ff @(posedge clk) host_rdata <= mem[host_addr];
   end else begin : g_rd_comb
      assign host_rdata = mem[host_addr];
   end

endmodule

// File: rtl/sector_bitfix.sv
module sector_bitfix
   import sbf_pkg::*;
#(
   parameter int SECTOR_BYTES = 512,
   parameter int ECC_BYTES    = 13,
   parameter int LOC_W        = 13,
   parameter int N_LOC        = 8,
   parameter int WORD_W       = 32,
   parameter int CORR_LIMIT   = 8,
   parameter int ADDR_W       = $clog2(SECTOR_BYTES),
   parameter int CNT_W        = $clog2(CORR_LIMIT + 1)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   start,
   input  logic [WORD_W-1:0]      res_w1,
   input  logic [WORD_W-1:0]      res_w2,
   input  logic [WORD_W-1:0]      res_w3,
   input  logic [WORD_W-1:0]      res_status,
   input  logic [ECC_BYTES*8-1:0] ecc_stored,
   input  logic                   host_we,
   input  logic [ADDR_W-1:0]      host_addr,
   input  logic [7:0]             host_wdata,
   output logic [7:0]             host_rdata,
   output logic                   done,
   output logic [CNT_W-1:0]       fix_count,
   output logic                   uncorrectable
);

   localparam int SECTOR_BITS = SECTOR_BYTES * 8;
   localparam int ACC_W       = $clog2(CORR_LIMIT + 9);
   localparam int NERR_LSB    = 10;
   localparam int NERR_W      = 4;
   localparam int EXT_LSB     = 16;
   localparam int EXT_W       = N_LOC * LOC_W - 3 * WORD_W;
   localparam int LSEL_W      = $clog2(N_LOC);
   localparam int EIDX_W      = $clog2(ECC_BYTES);
   localparam logic [WORD_W-1:0] USED_MASK =
      WORD_W'((((64'd1 << NERR_W) - 64'd1) << NERR_LSB) |
              (((64'd1 << EXT_W) - 64'd1) << EXT_LSB));

   initial begin
      if (LOC_W < ADDR_W + 3)
         $fatal(1, "sector_bitfix: location width cannot address the sector");
      if (CORR_LIMIT > N_LOC || CORR_LIMIT >= (1 << NERR_W))
         $fatal(1, "sector_bitfix: correction limit out of range");
      if (N_LOC < 2 || LSEL_W > NERR_W)
         $fatal(1, "sector_bitfix: location count out of range");
      if (EXT_LSB + EXT_W > WORD_W || NERR_LSB + NERR_W > EXT_LSB)
         $fatal(1, "sector_bitfix: status fields overlap or overflow");
   end

   // ---------------- latched operation context ----------------
   sbf_state_e             state_q;
   logic [WORD_W-1:0]      w1_q, w2_q, w3_q;
   logic [EXT_W-1:0]       ext_q;
   logic [ECC_BYTES*8-1:0] ecc_q;
   logic [NERR_W-1:0]      nerr_q, idx_q;
   logic [CNT_W-1:0]       applied_q, fix_count_q;
   logic [ACC_W-1:0]       total_q, dzero_q;
   logic [EIDX_W-1:0]      eptr_q;
   logic [ADDR_W-1:0]      bptr_q;
   logic                   unc_q;

   logic                   engine_busy;
   logic [NERR_W-1:0]      nerr_in;
   logic [WORD_W-1:0]      unused_status;

   assign engine_busy   = (state_q != ST_IDLE);
   assign nerr_in       = res_status[NERR_LSB +: NERR_W];
   assign unused_status = res_status & ~USED_MASK;

   // ---------------- location unpack and address forming ----------------
   logic [N_LOC-1:0][LOC_W-1:0] locs;
   logic [LOC_W-1:0]            cur_loc, bit_addr;
   logic                        in_range;
   logic [ADDR_W-1:0]           fix_byte;
   logic [2:0]                  fix_bit;

   sbf_loc_unpack #(
      .LOC_W (LOC_W),
      .N_LOC (N_LOC),
      .WORD_W(WORD_W),
      .EXT_W (EXT_W)
   ) u_unpack (
      .word1(w1_q),
      .word2(w2_q),
      .word3(w3_q),
      .ext  (ext_q),
      .locs (locs)
   );

   assign cur_loc  = locs[idx_q[LSEL_W-1:0]];
   assign bit_addr = cur_loc ^ LOC_W'(3);
   assign in_range = ({1'b0, bit_addr} < (LOC_W + 1)'(SECTOR_BITS));
   assign fix_byte = bit_addr[3 +: ADDR_W];
   assign fix_bit  = bit_addr[2:0];

   // ---------------- buffer and engine datapath ----------------
   logic [ADDR_W-1:0] eng_addr, ram_waddr;
   logic [7:0]        eng_rdata, eng_wdata, ram_wdata, ecc_byte, scan_byte;
   logic              eng_we, ram_we;
   logic [3:0]        zeros;
   logic [ACC_W-1:0]  tot_n, dz_n;
   logic              over_limit;

   assign eng_addr  = (state_q == ST_FIX) ? fix_byte : bptr_q;
   assign eng_we    = ((state_q == ST_FIX) && in_range) || (state_q == ST_ERASE);
   assign eng_wdata = (state_q == ST_ERASE) ? 8'hFF : (eng_rdata ^ (8'h01 << fix_bit));

   assign ram_we    = engine_busy ? eng_we    : host_we;
   assign ram_waddr = engine_busy ? eng_addr  : host_addr;
   assign ram_wdata = engine_busy ? eng_wdata : host_wdata;

   sbf_byte_ram #(
      .DEPTH      (SECTOR_BYTES),
      .DATA_W     (8),
      .HOST_RD_REG(1'b1)
   ) u_ram (
      .clk       (clk),
      .we        (ram_we),
      .waddr     (ram_waddr),
      .wdata     (ram_wdata),
      .eng_addr  (eng_addr),
      .eng_rdata (eng_rdata),
      .host_addr (host_addr),
      .host_rdata(host_rdata)
   );

   assign ecc_byte  = ecc_q[eptr_q*8 +: 8];
   assign scan_byte = (state_q == ST_ECC) ? ecc_byte : eng_rdata;

   sbf_zero_count #(.DATA_W(8), .CW(4)) u_zeros (
      .din  (scan_byte),
      .zeros(zeros)
   );

   assign tot_n      = total_q + ACC_W'(zeros);
   assign dz_n       = dzero_q + ACC_W'(zeros);
   assign over_limit = (tot_n > ACC_W'(CORR_LIMIT));

   // ---------------- sequencer ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= ST_IDLE;
         w1_q        <= '0;
         w2_q        <= '0;
         w3_q        <= '0;
         ext_q       <= '0;
         ecc_q       <= '0;
         nerr_q      <= '0;
         idx_q       <= '0;
         applied_q   <= '0;
         total_q     <= '0;
         dzero_q     <= '0;
         eptr_q      <= '0;
         bptr_q      <= '0;
         fix_count_q <= '0;
         unc_q       <= 1'b0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (start) begin
                  w1_q      <= res_w1;
                  w2_q      <= res_w2;
                  w3_q      <= res_w3;
                  ext_q     <= res_status[EXT_LSB +: EXT_W];
                  ecc_q     <= ecc_stored;
                  nerr_q    <= nerr_in;
                  idx_q     <= '0;
                  applied_q <= '0;
                  total_q   <= '0;
                  dzero_q   <= '0;
                  eptr_q    <= '0;
                  bptr_q    <= '0;
                  if (nerr_in == '0) begin
                     fix_count_q <= '0;
                     unc_q       <= 1'b0;
                     state_q     <= ST_DONE;
                  end else if (nerr_in <= NERR_W'(CORR_LIMIT)) begin
                     state_q <= ST_FIX;
                  end else begin
                     state_q <= ST_ECC;
                  end
               end
            end
            ST_FIX: begin
               applied_q <= applied_q + CNT_W'(in_range);
               idx_q     <= idx_q + NERR_W'(1);
               if ((idx_q + NERR_W'(1)) == nerr_q) begin
                  fix_count_q <= applied_q + CNT_W'(in_range);
                  unc_q       <= 1'b0;
                  state_q     <= ST_DONE;
               end
            end
            ST_ECC: begin
               total_q <= tot_n;
               eptr_q  <= eptr_q + EIDX_W'(1);
               if (over_limit) begin
                  fix_count_q <= '0;
                  unc_q       <= 1'b1;
                  state_q     <= ST_DONE;
               end else if (eptr_q == EIDX_W'(ECC_BYTES - 1)) begin
                  state_q <= ST_DATA;
               end
            end
            ST_DATA: begin
               total_q <= tot_n;
               dzero_q <= dz_n;
               bptr_q  <= bptr_q + ADDR_W'(1);
               if (over_limit) begin
                  fix_count_q <= '0;
                  unc_q       <= 1'b1;
                  state_q     <= ST_DONE;
               end else if (bptr_q == ADDR_W'(SECTOR_BYTES - 1)) begin
                  if (dz_n == '0) begin
                     fix_count_q <= '0;
                     unc_q       <= 1'b0;
                     state_q     <= ST_DONE;
                  end else begin
                     state_q <= ST_ERASE;
                  end
               end
            end
            ST_ERASE: begin
               bptr_q <= bptr_q + ADDR_W'(1);
               if (bptr_q == ADDR_W'(SECTOR_BYTES - 1)) begin
                  fix_count_q <= CNT_W'(dzero_q);
                  unc_q       <= 1'b0;
                  state_q     <= ST_DONE;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign done          = (state_q == ST_DONE);
   assign fix_count     = fix_count_q;
   assign uncorrectable = unc_q;

endmodule

// File: rtl/sbf_checker.sv
module sbf_checker #(
   parameter int CNT_W      = 4,
   parameter int NERR_W     = 4,
   parameter int CORR_LIMIT = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic [NERR_W-1:0] nerr_in,
   input logic              busy,
   input logic              done,
   input logic [CNT_W-1:0]  fix_count,
   input logic              uncorrectable
);

   // R2
   zero_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy && nerr_in == '0) |=> (done && fix_count == '0 && !uncorrectable));

   // R9
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R8
   unc_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && uncorrectable) |-> (fix_count == '0));

   // R5
   count_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (fix_count <= CNT_W'(CORR_LIMIT)));

   // R9
   count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(fix_count) || !$stable(uncorrectable)) |-> done);

endmodule

bind sector_bitfix sbf_checker u_sbf_checker (
   .clk          (clk),
   .rst_n        (rst_n),
   .start        (start),
   .nerr_in      (nerr_in),
   .busy         (engine_busy),
   .done         (done),
   .fix_count    (fix_count),
   .uncorrectable(uncorrectable)
);

// File: tb/sector_bitfix_test.sv
`timescale 1ns/1ps
module sector_bitfix_test;

   logic         clk = 1'b0;
   logic         rst_n = 1'b1;
   logic         start = 1'b0;
   logic [31:0]  res_w1 = '0, res_w2 = '0, res_w3 = '0, res_status = '0;
   logic [103:0] ecc_stored = '0;
   logic         host_we = 1'b0;
   logic [8:0]   host_addr = '0;
   logic [7:0]   host_wdata = '0;
   logic [7:0]   host_rdata;
   logic         done;
   logic [3:0]   fix_count;
   logic         uncorrectable;

   int checks = 0;
   int failures = 0;
   bit finished = 1'b0;

   logic [7:0]  model [512];
   logic [12:0] lv [8];
   int          got_cnt;
   bit          got_unc;

   always #2 clk = ~clk;

   sector_bitfix uut (
      .clk(clk), .rst_n(rst_n), .start(start),
      .res_w1(res_w1), .res_w2(res_w2), .res_w3(res_w3), .res_status(res_status),
      .ecc_stored(ecc_stored),
      .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
      .host_rdata(host_rdata),
      .done(done), .fix_count(fix_count), .uncorrectable(uncorrectable)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s: got %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic host_write(input int a, input logic [7:0] d);
      host_addr  = 9'(a);
      host_wdata = d;
      host_we    = 1'b1;
      @(negedge clk);
      host_we    = 1'b0;
      model[a]   = d;
   endtask

   task automatic load_sector(input int seed, input bit erased);
      for (int i = 0; i < 512; i++) begin
         if (erased) host_write(i, 8'hFF);
         else host_write(i, 8'((i * 37 + seed) ^ (i >> 3)));
      end
   endtask

   // compares the whole buffer against the bench model through the host port (R10)
   task automatic check_sector(input string tag);
      int bad = 0;
      int first = -1;
      logic [7:0] fa = '0, fe = '0;
      for (int i = 0; i < 512; i++) begin
         host_addr = 9'(i);
         @(negedge clk);
         if (host_rdata !== model[i]) begin
            bad++;
            if (first < 0) begin first = i; fa = host_rdata; fe = model[i]; end
         end
      end
      checks++;
      if (bad != 0) begin
         failures++;
         $display("FAIL %s: %0d bytes differ, first at %0d got %h expected %h",
                  tag, bad, first, fa, fe);
      end
   endtask

   function automatic void model_flip(input int addr);
      if (addr < 4096) model[addr >> 3][addr & 7] = ~model[addr >> 3][addr & 7];
   endfunction

   // packs lv[] per R3 and runs one operation; checks the done pulse (R9)
   task automatic run_op(input logic [3:0] nerr, input logic [103:0] ecc, input string tag);
      logic [103:0] flat;
      int cyc = 0;
      for (int k = 0; k < 8; k++) flat[13*k +: 13] = lv[k];
      res_w1     = flat[31:0];
      res_w2     = flat[63:32];
      res_w3     = flat[95:64];
      res_status = {8'hA5, flat[103:96], 2'b11, nerr, 10'h3C5};
      ecc_stored = ecc;
      start      = 1'b1;
      @(negedge clk);
      start      = 1'b0;
      while (!done && cyc < 3000) begin
         @(negedge clk);
         cyc++;
      end
      chk(done === 1'b1, {tag, " R9 done seen"}, int'(done), 1);
      got_cnt = int'(fix_count);
      got_unc = uncorrectable;
      repeat (3) @(negedge clk);
      chk(done === 1'b0, {tag, " R9 done one cycle"}, int'(done), 0);
      chk(int'(fix_count) == got_cnt && uncorrectable == got_unc,
          {tag, " R9 outputs held"}, int'(fix_count), got_cnt);
   endtask

   task automatic t_reset();
      chk(done === 1'b0, "R1 done after reset", int'(done), 0);
      chk(fix_count === 4'd0, "R1 count after reset", int'(fix_count), 0);
      chk(uncorrectable === 1'b0, "R1 flag after reset", int'(uncorrectable), 0);
   endtask

   task automatic t_zero();
      load_sector(5, 1'b0);
      check_sector("R10 host load");
      for (int k = 0; k < 8; k++) lv[k] = 13'(100 + k * 9);
      res_w1 = '0; res_w2 = '0; res_w3 = '0;
      res_status = {8'h00, 8'h00, 2'b00, 4'd0, 10'h000};
      for (int k = 0; k < 8; k++) res_w1[k] = 1'b1;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(done === 1'b1, "R2 done one edge after start", int'(done), 1);
      chk(fix_count === 4'd0 && uncorrectable === 1'b0, "R2 zero count",
          int'(fix_count), 0);
      @(negedge clk);
      check_sector("R2 buffer unchanged");
   endtask

   task automatic t_full8();
      load_sector(11, 1'b0);
      lv[0] = 13'h0003; lv[1] = 13'h0FFC; lv[2] = 13'h0ABC; lv[3] = 13'h0123;
      lv[4] = 13'h0800; lv[5] = 13'h0555; lv[6] = 13'h0AAA; lv[7] = 13'h0F0F;
      for (int k = 0; k < 8; k++) model_flip(int'(lv[k] ^ 13'h3));
      run_op(4'd8, '0, "R3 full");
      chk(got_cnt == 8 && !got_unc, "R3 R4 eight applied", got_cnt, 8);
      check_sector("R4 R3 eight flips incl. straddling locations");
   endtask

   task automatic t_partial();
      load_sector(23, 1'b0);
      lv[0] = 13'h1005; lv[1] = 13'h0010; lv[2] = 13'h1FFF; lv[3] = 13'h0040;
      lv[4] = 13'h0041; lv[5] = 13'h0042; lv[6] = 13'h0043; lv[7] = 13'h0044;
      model_flip(int'(13'h0010 ^ 13'h3));
      run_op(4'd3, '0, "R5 partial");
      chk(got_cnt == 1 && !got_unc, "R5 R6 only in-range counted", got_cnt, 1);
      check_sector("R6 R5 later locations unused");
   endtask

   task automatic t_dup();
      load_sector(41, 1'b0);
      for (int k = 0; k < 8; k++) lv[k] = 13'h0777;
      run_op(4'd2, '0, "R5 repeat");
      chk(got_cnt == 2, "R5 repeated location counted twice", got_cnt, 2);
      check_sector("R5 double flip restores byte");
   endtask

   task automatic t_erased(input int dzeros, input int ezeros, input logic [3:0] nerr,
                           input string tag);
      logic [103:0] ecc = '1;
      load_sector(0, 1'b1);
      for (int i = 0; i < dzeros; i++) host_write(i * 61 + 3, 8'hFE);
      for (int j = 0; j < ezeros; j++) ecc[j * 8 + 4] = 1'b0;
      for (int k = 0; k < 8; k++) lv[k] = 13'h0020;
      if (dzeros + ezeros <= 8) begin
         for (int i = 0; i < 512; i++) model[i] = 8'hFF;
      end
      run_op(nerr, ecc, tag);
      if (dzeros + ezeros <= 8) begin
         chk(got_cnt == dzeros && !got_unc, {tag, " R7 erased count"}, got_cnt, dzeros);
         check_sector({tag, " R7 sector all ones"});
      end else begin
         chk(got_unc && got_cnt == 0, {tag, " R8 uncorrectable"}, int'(got_unc), 1);
         check_sector({tag, " R8 sector unchanged"});
      end
   endtask

   task automatic t_ecc_over();
      logic [103:0] ecc = '1;
      load_sector(77, 1'b0);
      ecc[7:0]   = 8'h00;
      ecc[15:14] = 2'b00;
      for (int k = 0; k < 8; k++) lv[k] = 13'h0020;
      run_op(4'd12, ecc, "R8 ecc");
      chk(got_unc && got_cnt == 0, "R8 ecc bytes alone exceed limit", int'(got_unc), 1);
      check_sector("R8 data untouched");
   endtask

   initial begin
      #800000;
      if (!finished) begin
         failures++;
         checks++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      #1 rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_zero();
      t_full8();
      t_partial();
      t_dup();
      t_erased(3, 2, 4'd9,  "erased5");
      t_erased(5, 3, 4'd15, "edge8");
      t_erased(6, 3, 4'd10, "edge9");
      t_erased(0, 8, 4'd9,  "ecconly8");
      t_ecc_over();
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule